// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Front End

This block is the command-decoding front end of a serial NOR flash model, seen from the SPI side as a mode-0 slave. It keeps the status register, decodes the status, write-enable, program and erase commands, and decides whether each program or erase request may go ahead. An accepted or refused request is announced with a one-cycle strobe carrying the command kind and its 24-bit address. The memory array and its timing sit behind this block and are not modelled. A simple countdown stands in for the write-in-progress state.

The SPI lines are treated as synchronous inputs of the block clock. Clock edges are found by comparing each sample with the one before. Protection comes from two sources. A 3-bit protect level selects a top region of a 64-sector array. A lock mode formed by the status-write-disable bit and a low write-protect pin freezes the status register.

Top module: `sflash_guard`

## Requirements
- R1: During and right after reset the status byte is 0x00, `spi_miso_oe` is low and neither `op_accept` nor `op_reject` is high.
- R2: A status read (opcode 0x05, shifted in MSB first on rising SCLK) leaves `spi_miso_oe` low during the 8 opcode bits. It then drives the status byte MSB first, one bit per SCLK period, changing after falling SCLK. Layout: bit 7 write-disable, bits 4:2 protect level, bit 1 write-enable latch (WEL), bit 0 write-in-progress (WIP), other bits 0.
- R3: While chip select stays low after a status read opcode, the status byte repeats on the output for every further 8 clocks.
- R4: Write enable (0x06, exactly one byte) sets WEL. A status write, program or erase sent while WEL is clear has no effect and gives no strobe.
- R5: Status write (0x01 followed by one data byte, exactly two bytes) copies data bit 7 and bits 4:2 into the status register, clears WEL and sets WIP, provided lock mode is off.
- R6: Lock mode is on when bit 7 is 1 and `wp_n` is low. In lock mode a status write changes neither bit 7 nor the protect level, does not set WIP, and still clears WEL.
- R7: Page program (0x02, at least 4 bytes) and sector erase (0xD8, exactly 4 bytes) carry a 24-bit address, MSB first. On chip-select rise they pulse `op_accept` if the target is unprotected, else `op_reject`. `op_kind` is 0 for program, 1 for sector erase and 2 for bulk erase, and `op_addr` holds the address. Both strobes are never high together.
- R8: The sector is address bits 23:18. Protect level N in 1..6 covers sectors 64-2^(N-1) to 63, level 7 covers all sectors, and level 0 covers none.
- R9: Bulk erase (0xC7, exactly one byte) is accepted only when the protect level is 0; otherwise it is rejected.
- R10: A command whose chip select rises when the bit count is not a multiple of 8 is not executed and leaves WEL unchanged.
- R11: A program or erase command clears WEL whether it is accepted or rejected.
- R12: An accepted program or erase sets WIP for BUSY_CYCLES clocks. While WIP is set, every command except status read is ignored and no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, SPI lines are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data into the block |
| wp_n | input | 1 | Active-low write-protect pin |
| spi_miso | output | 1 | Serial data out (status bits) |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high impedance |
| op_accept | output | 1 | One-cycle pulse: program or erase allowed |
| op_reject | output | 1 | One-cycle pulse: program or erase refused |
| op_kind | output | 2 | Kind of the announced request (0 program, 1 sector erase, 2 bulk erase) |
| op_addr | output | ADDR_W | Address of the announced request |

## Verification
The assertions guard the invariants on every cycle. Accept and reject never coincide. An accepted program or erase never lands in the protected region. Bulk erase is only accepted with a clear protect level. Lock mode freezes the protected status bits. No strobe comes out while busy, and an acceptance always starts the busy state. Only the bench's scenarios show the serial-side behaviour. These cover the bit order and repetition of the status byte, the high-impedance opcode phase, WEL set and clear, misaligned chip-select rises, and the region boundary for each protect level.

// File: rtl/sflash_guard.sv
module sflash_guard #(
  parameter int ADDR_W      = 24,
  parameter int SECTOR_BITS = 6,
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic              wp_n,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              op_accept,
  output logic              op_reject,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr
);
  localparam int SECTORS    = 1 << SECTOR_BITS;
  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int BW         = $clog2(BUSY_CYCLES + 1);

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;

  localparam logic [1:0] K_PP = 2'd0;
  localparam logic [1:0] K_SE = 2'd1;
  localparam logic [1:0] K_BE = 2'd2;

  logic              sclk_q, cs_q;
  logic [2:0]        bitpos, nbytes, rd_idx;
  logic [6:0]        shreg;
  logic [7:0]        opcode, rd_snap;
  logic [ADDR_W-1:0] addr_q;
  logic              srwd, wel, miso_q, oe_q;
  logic [2:0]        bp;
  logic [BW-1:0]     busy_cnt;

  function automatic logic in_prot(input logic [2:0] lvl, input logic [SECTOR_BITS-1:0] sec);
    if (lvl == 3'd0) return 1'b0;
    if (lvl == 3'd7) return 1'b1;
    return int'(sec) >= SECTORS - (1 << (lvl - 3'd1));
  endfunction

  wire sclk_rise = spi_sclk & ~sclk_q;
  wire sclk_fall = ~spi_sclk & sclk_q;
  wire cs_rise   = spi_cs_n & ~cs_q;
  wire wip       = busy_cnt != '0;
  wire hpm       = srwd & ~wp_n;
  wire [7:0] status    = {srwd, 2'b00, bp, wel, wip};
  wire [7:0] next_byte = {shreg, spi_mosi};
  wire reading   = (nbytes != 3'd0) && (opcode == OP_RDSR);
  wire exec_ok   = cs_rise && !wip && (bitpos == 3'd0);
  wire [SECTOR_BITS-1:0] cmd_sector = addr_q[ADDR_W-1 -: SECTOR_BITS];

  assign spi_miso    = miso_q;
  assign spi_miso_oe = oe_q & ~spi_cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; cs_q <= 1'b1;
      bitpos <= '0; nbytes <= '0; rd_idx <= '0;
      shreg <= '0; opcode <= '0; rd_snap <= '0; addr_q <= '0;
      srwd <= 1'b0; wel <= 1'b0; bp <= '0; busy_cnt <= '0;
      miso_q <= 1'b0; oe_q <= 1'b0;
      op_accept <= 1'b0; op_reject <= 1'b0; op_kind <= K_PP; op_addr <= '0;
    end else begin
      sclk_q    <= spi_sclk;
      cs_q      <= spi_cs_n;
      op_accept <= 1'b0;
      op_reject <= 1'b0;
      if (wip) busy_cnt <= busy_cnt - 1'b1;

      if (spi_cs_n) begin
        bitpos <= '0; nbytes <= '0; rd_idx <= '0; oe_q <= 1'b0;
      end else begin
        if (sclk_rise) begin
          shreg  <= next_byte[6:0];
          bitpos <= bitpos + 1'b1;
          if (bitpos == 3'd7 && nbytes != 3'd7) nbytes <= nbytes + 1'b1;
          if (bitpos == 3'd7 && nbytes == 3'd0) opcode <= next_byte;
          if (nbytes != 3'd0 && int'(nbytes) <= ADDR_BYTES)
            addr_q <= {addr_q[ADDR_W-2:0], spi_mosi};
        end
        if (sclk_fall && reading) begin
          oe_q   <= 1'b1;
          rd_idx <= rd_idx + 1'b1;
          if (rd_idx == 3'd0) begin
            miso_q  <= status[7];
            rd_snap <= status;
          end else begin
            miso_q <= rd_snap[3'd7 - rd_idx];
          end
        end
      end

      if (exec_ok && opcode == OP_WREN && nbytes == 3'd1) wel <= 1'b1;

      if (exec_ok && wel) begin
        case (opcode)
          OP_WRSR: if (nbytes == 3'd2) begin
            wel <= 1'b0;
            if (!hpm) begin
              srwd     <= addr_q[7];
              bp       <= addr_q[4:2];
              busy_cnt <= BW'(BUSY_CYCLES);
            end
          end
          OP_PP, OP_SE: if ((opcode == OP_PP && nbytes >= 3'd4) || nbytes == 3'd4) begin
            wel     <= 1'b0;
            op_kind <= (opcode == OP_PP) ? K_PP : K_SE;
            op_addr <= addr_q;
            if (in_prot(bp, cmd_sector)) op_reject <= 1'b1;
            else begin
              op_accept <= 1'b1;
              busy_cnt  <= BW'(BUSY_CYCLES);
            end
          end
          OP_BE: if (nbytes == 3'd1) begin
            wel     <= 1'b0;
            op_kind <= K_BE;
            op_addr <= '0;
            if (bp != 3'd0) op_reject <= 1'b1;
            else begin
              op_accept <= 1'b1;
              busy_cnt  <= BW'(BUSY_CYCLES);
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: a request gets a single verdict
  a_r7_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_accept && op_reject));

  // R8: an accepted program or sector erase lies outside the covered region
  a_r8_accept_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (op_accept && op_kind != K_BE) |-> !in_prot(bp, op_addr[ADDR_W-1 -: SECTOR_BITS]));

  // R9: bulk erase only passes with a clear protect level
  a_r9_bulk_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (op_accept && op_kind == K_BE) |-> bp == 3'd0);

  // R6: lock mode freezes write-disable and protect level
  a_r6_lock_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hpm) |-> ($stable(srwd) && $stable(bp)));

  // R12: nothing is announced while busy
  a_r12_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wip) |-> (!op_accept && !op_reject));

  // R12: an acceptance starts the busy state
  a_r12_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    op_accept |-> wip);
endmodule

// File: tb/test_sflash_guard.sv
module test_sflash_guard;
  localparam int BUSY = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
  logic miso, miso_oe, op_accept, op_reject;
  logic [1:0] op_kind;
  logic [23:0] op_addr;

  int checks = 0, fails = 0;
  logic oe_seen, oe_data;
  logic got_acc, got_rej;
  logic [1:0] got_kind;
  logic [23:0] got_addr;
  logic [7:0] st;

  always #2 clk = ~clk;

  sflash_guard #(.ADDR_W(24), .SECTOR_BITS(6), .BUSY_CYCLES(BUSY)) i_sflash_guard (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .wp_n(wp_n), .spi_miso(miso), .spi_miso_oe(miso_oe), .op_accept(op_accept),
    .op_reject(op_reject), .op_kind(op_kind), .op_addr(op_addr));

  // {protect level, opcode, address, expect accept}
  localparam logic [35:0] VEC [10] = '{
    {3'd0, 8'h02, 24'hFFFFFF, 1'b1},
    {3'd1, 8'hD8, 24'hFC0000, 1'b0},
    {3'd1, 8'hD8, 24'hF80000, 1'b1},
    {3'd3, 8'h02, 24'hF00000, 1'b0},
    {3'd3, 8'h02, 24'hEC0000, 1'b1},
    {3'd6, 8'hD8, 24'h800000, 1'b0},
    {3'd6, 8'hD8, 24'h7C0000, 1'b1},
    {3'd7, 8'h02, 24'h000000, 1'b0},
    {3'd2, 8'hD8, 24'hF80000, 1'b0},
    {3'd2, 8'h02, 24'hF40000, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic r);
    @(negedge clk); sclk = 1'b0; mosi = b;
    repeat (2) @(negedge clk);
    r = miso; oe_seen |= miso_oe; oe_data = miso_oe;
    sclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spi_bit(b[i], r[i]);
  endtask

  task automatic cs_lo();
    @(negedge clk); sclk = 1'b0; cs_n = 1'b0;
  endtask

  task automatic cs_hi();
    @(negedge clk); sclk = 1'b0;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    got_acc = op_accept; got_rej = op_reject; got_kind = op_kind; got_addr = op_addr;
    @(negedge clk);
  endtask

  task automatic rdsr(output logic [7:0] s, output logic op_oe);
    logic [7:0] d;
    cs_lo(); oe_seen = 1'b0;
    spi_byte(8'h05, d);
    op_oe = oe_seen;
    spi_byte(8'h00, s);
    cs_hi();
  endtask

  task automatic wait_idle(output logic [7:0] s);
    logic o;
    for (int k = 0; k < 60; k++) begin
      rdsr(s, o);
      if (!s[0]) break;
    end
  endtask

  task automatic wren();
    logic [7:0] d;
    cs_lo(); spi_byte(8'h06, d); cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_lo(); spi_byte(8'h01, d); spi_byte(v, d); cs_hi();
  endtask

  task automatic addr_cmd(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] d;
    cs_lo(); spi_byte(op, d);
    spi_byte(a[23:16], d); spi_byte(a[15:8], d); spi_byte(a[7:0], d);
    cs_hi();
  endtask

  task automatic bulk();
    logic [7:0] d;
    cs_lo(); spi_byte(8'hC7, d); cs_hi();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic o, b;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    chk("R1 accept in reset", {31'd0, op_accept}, 0);
    chk("R1 reject in reset", {31'd0, op_reject}, 0);
    chk("R1 oe in reset", {31'd0, miso_oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    rdsr(st, o);
    chk("R1 status after reset", {24'd0, st}, 32'h00);
    chk("R2 oe low during opcode", {31'd0, o}, 0);
    chk("R2 oe high during data", {31'd0, oe_data}, 1);

    addr_cmd(8'h02, 24'h001000);
    chk("R4 program without WEL: no strobe", {30'd0, got_acc, got_rej}, 0);

    wren();
    rdsr(st, o);
    chk("R4 WEL set", {24'd0, st}, 32'h02);

    // R10: misaligned chip-select rise
    cs_lo(); spi_byte(8'hD8, d); spi_byte(8'h00, d); spi_byte(8'h00, d); spi_byte(8'h00, d);
    for (int i = 0; i < 4; i++) spi_bit(1'b0, b);
    cs_hi();
    chk("R10 misaligned: no strobe", {30'd0, got_acc, got_rej}, 0);

    // R3: status repeats while chip select stays low
    cs_lo(); spi_byte(8'h05, d);
    for (int n = 0; n < 3; n++) begin
      spi_byte(8'h00, d);
      chk("R3 repeated status byte (R10 WEL kept)", {24'd0, d}, 32'h02);
    end
    cs_hi();

    for (int v = 0; v < 10; v++) begin
      wren();
      wrsr({3'b000, VEC[v][35:33], 2'b00});
      wait_idle(st);
      chk("R5 protect level written", {24'd0, st}, {24'd0, 3'b000, VEC[v][35:33], 2'b00});
      wren();
      addr_cmd(VEC[v][32:25], VEC[v][24:1]);
      chk("R7 R8 verdict", {30'd0, got_acc, got_rej}, {30'd0, VEC[v][0], ~VEC[v][0]});
      chk("R7 kind", {30'd0, got_kind}, (VEC[v][32:25] == 8'h02) ? 0 : 1);
      chk("R7 address", {8'd0, got_addr}, {8'd0, VEC[v][24:1]});
      wait_idle(st);
      chk("R11 WEL cleared after verdict", {31'd0, st[1]}, 0);
    end

    wren(); bulk();
    chk("R9 bulk with protect level: reject", {30'd0, got_acc, got_rej}, 32'b01);
    wren(); wrsr(8'h00); wait_idle(st);
    wren(); bulk();
    chk("R9 bulk with clear level: accept", {30'd0, got_acc, got_rej}, 32'b10);
    chk("R9 bulk kind", {30'd0, got_kind}, 2);
    rdsr(st, o);
    chk("R12 WIP after accept", {24'd0, st}, 32'h01);
    wren();
    rdsr(st, o);
    chk("R12 WEL not set while busy", {24'd0, st}, 32'h01);
    addr_cmd(8'h02, 24'h000000);
    chk("R12 no strobe while busy", {30'd0, got_acc, got_rej}, 0);
    wait_idle(st);
    chk("R12 WIP clears", {24'd0, st}, 32'h00);

    wren(); wrsr(8'h84); wait_idle(st);
    chk("R5 write-disable bit written", {24'd0, st}, 32'h84);
    wp_n = 1'b0;
    wren(); wrsr(8'h00);
    rdsr(st, o);
    chk("R6 lock mode keeps status, WEL cleared", {24'd0, st}, 32'h84);
    wp_n = 1'b1;
    wren(); wrsr(8'h00);
    rdsr(st, o);
    chk("R5 WIP set by status write", {31'd0, st[0]}, 1);
    wait_idle(st);
    chk("R6 unlocked status write", {24'd0, st}, 32'h00);

    finish_run();
  end
endmodule